// File: doc/BRIEF.md
# Receive Frame Filter and Header Builder

This block sits between a receive MAC and a single frame buffer. Frames arrive as a byte stream marked by start, valid and end strobes. The block checks the destination address against the broadcast address and against its own station address. An accepted frame is copied into the buffer after a four-byte receive header. The block then advances the ring's current-page pointer as if the frame had been stored in 256-byte pages, and raises a receive-good interrupt.

Only one frame is held at a time. After a frame is stored, a lock is set and every later frame is ignored until the host acknowledges the receive interrupt. The register file around the block supplies the ring bounds and the current page. It takes the updated page back and passes on the host's acknowledge.

Top module: `rxf_rx_engine`

## Requirements
- R1: After reset, `buf_we`, `rx_irq`, `curr_we` and `rx_busy` are all 0.
- R2: A frame is accepted only when its first six bytes are all 0xFF, or when they equal the station address, with byte 0 compared to `station_addr[47:40]` and byte 5 to `station_addr[7:0]`. A rejected frame writes no header, raises no interrupt and does not change the page.
- R3: Frame byte i is written at buffer address 4+i. While the destination is still being compared, a byte is written only if every destination byte so far, including this one, still matches one of the two accepted addresses.
- R4: A frame of more than 1536 bytes is dropped. The first 1536 bytes may already be in the buffer, but no header, interrupt or page change follows.
- R5: The reported length is the received byte count, raised to 64 if smaller. For a short frame of n bytes, zero bytes are written at addresses 4+n through 67. Header bytes 2 and 3 hold the reported length, low byte first.
- R6: The page count is 1 + ((length + 4) >> 8). The page pointer, loaded from `curr_in` at frame start, is incremented once per page and reloads `ring_start` whenever it becomes equal to `ring_stop`. The final value is presented on `curr_next` with a one-cycle `curr_we`.
- R7: Header byte 0 (address 0) is the status value 0x01 and byte 1 is the updated page pointer. The header is written after all frame data and padding, in address order 0 to 3.
- R8: In the same cycle as the write of header byte 3, `rx_irq` pulses for one cycle and `rx_busy` rises.
- R9: While `rx_busy` is 1, incoming frames cause no buffer write, no page change and no interrupt. A pulse on `rx_ack` clears `rx_busy`. An `rx_ack` while not busy has no effect.
- R10: A frame that ends before its sixth byte is dropped without header, interrupt or page change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_sof | input | 1 | Marks the first byte of a frame (qualified by rx_valid) |
| rx_valid | input | 1 | A byte is present on rx_data |
| rx_eof | input | 1 | Marks the last byte of a frame (qualified by rx_valid) |
| rx_data | input | 8 | Frame byte |
| station_addr | input | 48 | Station address, first byte on the wire in bits 47:40 |
| ring_start | input | 8 | First page of the receive ring |
| ring_stop | input | 8 | Page one past the end of the ring |
| curr_in | input | 8 | Current page from the register file |
| rx_ack | input | 1 | Host acknowledge of the receive interrupt |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 11 | Buffer byte address |
| buf_wdata | output | 8 | Buffer write data |
| curr_we | output | 1 | Load strobe for the updated current page |
| curr_next | output | 8 | Updated current page |
| rx_irq | output | 1 | One-cycle receive-good interrupt |
| rx_busy | output | 1 | Lock: a stored frame awaits acknowledge |

## Verification
The hardest case to reach is the ring wrap occurring in the middle of a multi-page advance, so that header byte 1 shows the reloaded start page plus the remaining increments. The stimulus seeds the current page just below the stop page and then sends a 300-byte frame and a full 1536-byte frame, which consume two and seven pages. Partial destination matches are also hard to observe, because they only show up as a short run of buffer writes. Frames whose destinations diverge at byte 0, byte 3 and byte 5 expose exactly where writing stops.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    // Receive header is fixed at four bytes: status, next page, length lo, length hi
    localparam int RXF_HDR_BYTES = 4;
    localparam logic [7:0] RXF_STATUS_OK = 8'h01;
    localparam logic [7:0] RXF_BCAST_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RECV = 3'd1,
        ST_DROP = 3'd2,
        ST_PAD  = 3'd3,
        ST_PAGE = 3'd4,
        ST_HDR  = 3'd5
    } rxf_state_e;

endpackage

// File: rtl/rxf_dest_match.sv
module rxf_dest_match #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = 12
) (
    input  logic [7:0]              byte_i,
    input  logic [IDX_W-1:0]        idx_i,
    input  logic [8*ADDR_BYTES-1:0] station_i,
    output logic                    bcast_o,
    output logic                    own_o
);
    import rxf_pkg::*;

    logic [ADDR_BYTES-1:0] hit;

    // One comparator per destination position; byte 0 is the most significant
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_pos
        logic [7:0] stn_byte;
        assign stn_byte = station_i[8*(ADDR_BYTES-g)-1 -: 8];
        assign hit[g]   = (idx_i == IDX_W'(g)) && (byte_i == stn_byte);
    end

    assign own_o   = |hit;
    assign bcast_o = (byte_i == RXF_BCAST_BYTE);

endmodule

// File: rtl/rxf_page_count.sv
module rxf_page_count #(
    parameter int CNT_W      = 12,
    parameter int LEN_W      = 16,
    parameter int MIN_FRAME  = 64,
    parameter int HDR_BYTES  = 4,
    parameter int PAGE_SHIFT = 8
) (
    input  logic [CNT_W-1:0] len_i,
    output logic [LEN_W-1:0] rep_len_o,
    output logic [CNT_W-1:0] pages_o
);
    logic [LEN_W-1:0] raw;
    logic [LEN_W-1:0] span;

    always_comb begin
        raw       = LEN_W'(len_i);
        rep_len_o = (raw < LEN_W'(MIN_FRAME)) ? LEN_W'(MIN_FRAME) : raw;
        span      = rep_len_o + LEN_W'(HDR_BYTES);
        pages_o   = CNT_W'(span >> PAGE_SHIFT) + CNT_W'(1);
    end

endmodule

// File: rtl/rxf_ring_step.sv
module rxf_ring_step #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] cur_i,
    input  logic [PAGE_W-1:0] start_i,
    input  logic [PAGE_W-1:0] stop_i,
    output logic [PAGE_W-1:0] next_o
);
    logic [PAGE_W-1:0] inc;

    always_comb begin
        inc    = cur_i + PAGE_W'(1);
        next_o = (inc == stop_i) ? start_i : inc;
    end

endmodule

// File: rtl/rxf_rx_engine.sv
module rxf_rx_engine #(
    parameter int MAX_FRAME  = 1536,
    parameter int MIN_FRAME  = 64,
    parameter int ADDR_BYTES = 6,
    parameter int PAGE_SHIFT = 8,
    parameter int PAGE_W     = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_sof,
    input  logic                    rx_valid,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    input  logic [PAGE_W-1:0]       ring_start,
    input  logic [PAGE_W-1:0]       ring_stop,
    input  logic [PAGE_W-1:0]       curr_in,
    input  logic                    rx_ack,
    output logic                    buf_we,
    output logic [$clog2(MAX_FRAME+rxf_pkg::RXF_HDR_BYTES)-1:0] buf_addr,
    output logic [7:0]              buf_wdata,
    output logic                    curr_we,
    output logic [PAGE_W-1:0]       curr_next,
    output logic                    rx_irq,
    output logic                    rx_busy
);
    import rxf_pkg::*;

    localparam int BUF_DEPTH = MAX_FRAME + RXF_HDR_BYTES;
    localparam int BUF_AW    = $clog2(BUF_DEPTH);
    localparam int CNT_W     = $clog2(MAX_FRAME + 1) + 1;
    localparam int LEN_W     = 16;
    localparam int HIDX_W    = $clog2(RXF_HDR_BYTES);
    localparam logic [BUF_AW-1:0] DATA_OFS = BUF_AW'(RXF_HDR_BYTES);

    typedef struct packed {
        rxf_state_e        state;
        logic              lock;
        logic              bc;
        logic              uc;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  pages;
        logic [LEN_W-1:0]  len;
        logic [HIDX_W-1:0] hidx;
        logic [PAGE_W-1:0] page;
        logic              buf_we;
        logic [BUF_AW-1:0] buf_addr;
        logic [7:0]        buf_wdata;
        logic              irq;
        logic              curr_we;
    } rxf_regs_t;

    rxf_regs_t q, d;

    logic              m_bc, m_uc;
    logic [CNT_W-1:0]  match_idx;
    logic [CNT_W-1:0]  cnt_inc;
    logic [LEN_W-1:0]  rep_len;
    logic [CNT_W-1:0]  page_total;
    logic [PAGE_W-1:0] page_step;

    assign match_idx = (q.state == ST_IDLE) ? '0 : q.cnt;
    assign cnt_inc   = q.cnt + CNT_W'(1);

    rxf_dest_match #(
        .ADDR_BYTES (ADDR_BYTES),
        .IDX_W      (CNT_W)
    ) u_match (
        .byte_i    (rx_data),
        .idx_i     (match_idx),
        .station_i (station_addr),
        .bcast_o   (m_bc),
        .own_o     (m_uc)
    );

    rxf_page_count #(
        .CNT_W      (CNT_W),
        .LEN_W      (LEN_W),
        .MIN_FRAME  (MIN_FRAME),
        .HDR_BYTES  (RXF_HDR_BYTES),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_pages (
        .len_i     (cnt_inc),
        .rep_len_o (rep_len),
        .pages_o   (page_total)
    );

    rxf_ring_step #(
        .PAGE_W (PAGE_W)
    ) u_step (
        .cur_i   (q.page),
        .start_i (ring_start),
        .stop_i  (ring_stop),
        .next_o  (page_step)
    );

    logic       bc_n, uc_n, keep;
    logic [7:0] hdr_byte;

    always_comb begin
        d           = q;
        d.buf_we    = 1'b0;
        d.irq       = 1'b0;
        d.curr_we   = 1'b0;

        bc_n = q.bc;
        uc_n = q.uc;
        if (q.cnt < CNT_W'(ADDR_BYTES)) begin
            bc_n = q.bc & m_bc;
            uc_n = q.uc & m_uc;
        end
        keep = bc_n | uc_n;

        unique case (q.hidx)
            2'd0:    hdr_byte = RXF_STATUS_OK;
            2'd1:    hdr_byte = q.page;
            2'd2:    hdr_byte = q.len[7:0];
            default: hdr_byte = q.len[15:8];
        endcase

        // host acknowledge releases the lock; a set lock only exists in idle
        if (q.lock && rx_ack) begin
            d.lock = 1'b0;
        end

        unique case (q.state)
            ST_IDLE: begin
                if (!q.lock && rx_valid && rx_sof) begin
                    d.cnt  = CNT_W'(1);
                    d.bc   = m_bc;
                    d.uc   = m_uc;
                    d.page = curr_in;
                    if (m_bc || m_uc) begin
                        d.buf_we    = 1'b1;
                        d.buf_addr  = DATA_OFS;
                        d.buf_wdata = rx_data;
                    end
                    if (rx_eof) begin
                        d.state = ST_IDLE;
                    end else if (m_bc || m_uc) begin
                        d.state = ST_RECV;
                    end else begin
                        d.state = ST_DROP;
                    end
                end
            end

            ST_RECV: begin
                if (rx_valid) begin
                    if (q.cnt == CNT_W'(MAX_FRAME)) begin
                        d.state = rx_eof ? ST_IDLE : ST_DROP;
                    end else begin
                        d.bc  = bc_n;
                        d.uc  = uc_n;
                        d.cnt = cnt_inc;
                        if (keep) begin
                            d.buf_we    = 1'b1;
                            d.buf_addr  = DATA_OFS + q.cnt[BUF_AW-1:0];
                            d.buf_wdata = rx_data;
                        end
                        if (!keep) begin
                            d.state = rx_eof ? ST_IDLE : ST_DROP;
                        end else if (rx_eof) begin
                            if (cnt_inc < CNT_W'(ADDR_BYTES)) begin
                                d.state = ST_IDLE;
                            end else begin
                                d.len   = rep_len;
                                d.pages = page_total;
                                d.state = (cnt_inc < CNT_W'(MIN_FRAME)) ? ST_PAD : ST_PAGE;
                            end
                        end
                    end
                end
            end

            ST_DROP: begin
                if (rx_valid && rx_eof) begin
                    d.state = ST_IDLE;
                end
            end

            ST_PAD: begin
                d.buf_we    = 1'b1;
                d.buf_addr  = DATA_OFS + q.cnt[BUF_AW-1:0];
                d.buf_wdata = 8'h00;
                d.cnt       = cnt_inc;
                if (q.cnt == CNT_W'(MIN_FRAME - 1)) begin
                    d.state = ST_PAGE;
                end
            end

            ST_PAGE: begin
                d.page  = page_step;
                d.pages = q.pages - CNT_W'(1);
                if (q.pages == CNT_W'(1)) begin
                    d.hidx  = '0;
                    d.state = ST_HDR;
                end
            end

            ST_HDR: begin
                d.buf_we    = 1'b1;
                d.buf_addr  = BUF_AW'(q.hidx);
                d.buf_wdata = hdr_byte;
                d.hidx      = q.hidx + HIDX_W'(1);
                if (q.hidx == HIDX_W'(RXF_HDR_BYTES - 1)) begin
                    d.lock    = 1'b1;
                    d.irq     = 1'b1;
                    d.curr_we = 1'b1;
                    d.state   = ST_IDLE;
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign buf_we    = q.buf_we;
    assign buf_addr  = q.buf_addr;
    assign buf_wdata = q.buf_wdata;
    assign curr_we   = q.curr_we;
    assign curr_next = q.page;
    assign rx_irq    = q.irq;
    assign rx_busy   = q.lock;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
    parameter int AW     = 11,
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_ack,
    input logic [PAGE_W-1:0] ring_start,
    input logic [PAGE_W-1:0] ring_stop,
    input logic              buf_we,
    input logic [AW-1:0]     buf_addr,
    input logic [7:0]        buf_wdata,
    input logic              curr_we,
    input logic [PAGE_W-1:0] curr_next,
    input logic              rx_irq,
    input logic              rx_busy
);

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    p_lock_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_busy) |-> (rx_irq && buf_we && buf_addr == AW'(3)));

    p_quiet_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && $past(rx_busy)) |-> (!buf_we && !curr_we && !rx_irq));

    p_hold_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_busy && !rx_ack) |=> rx_busy);

    p_ring_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (curr_we && ring_start < ring_stop) |-> (curr_next >= ring_start && curr_next < ring_stop));

    p_page_with_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        curr_we |-> rx_irq);

    p_status_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we && buf_addr == '0) |-> buf_wdata == 8'h01);

endmodule

bind rxf_rx_engine rxf_checker #(.AW(11), .PAGE_W(8)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_ack     (rx_ack),
    .ring_start (ring_start),
    .ring_stop  (ring_stop),
    .buf_we     (buf_we),
    .buf_addr   (buf_addr),
    .buf_wdata  (buf_wdata),
    .curr_we    (curr_we),
    .curr_next  (curr_next),
    .rx_irq     (rx_irq),
    .rx_busy    (rx_busy)
);

// File: tb/tb_rxf_rx_engine.sv
module tb_rxf_rx_engine;

    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] STN = 48'h021A_4C99_E037;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [7:0]  ring_start = 8'h46, ring_stop = 8'h80, curr_reg = 8'h46;
    logic        rx_ack = 1'b0;
    logic        buf_we, curr_we, rx_irq, rx_busy;
    logic [10:0] buf_addr;
    logic [7:0]  buf_wdata, curr_next;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxf_rx_engine dut (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_eof(rx_eof),
        .rx_data(rx_data), .station_addr(STN), .ring_start(ring_start), .ring_stop(ring_stop),
        .curr_in(curr_reg), .rx_ack(rx_ack), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .curr_we(curr_we), .curr_next(curr_next), .rx_irq(rx_irq),
        .rx_busy(rx_busy)
    );

    int    n_checks = 0, n_errs = 0;
    int    exp_addr[$];
    int    exp_data[$];
    string exp_tag[$];
    logic [7:0] frame_q[$];
    bit    model_lock = 0, irq_armed = 0, finished = 0;
    int    irq_seen = 0, curr_events = 0, exp_curr = 0;
    logic [7:0] seen_curr = 8'h00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the write port, interrupt and page update
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (buf_we) begin
                if (exp_addr.size() == 0) begin
                    chk(0, "R9 unexpected buffer write", {buf_addr, buf_wdata}, 0);
                end else begin
                    int a, v;
                    string t;
                    a = exp_addr.pop_front();
                    v = exp_data.pop_front();
                    t = exp_tag.pop_front();
                    chk(buf_addr == a && buf_wdata == v, t, {buf_addr, buf_wdata}, (a << 8) | v);
                end
            end
            if (rx_irq) begin
                irq_seen++;
                chk(irq_armed, "R8 interrupt only after accepted frame", 1, irq_armed);
                chk(rx_busy && buf_we && buf_addr == 3, "R8 irq with lock and last header byte",
                    {rx_busy, buf_we, buf_addr}, {1'b1, 1'b1, 11'd3});
                irq_armed = 0;
            end
            if (curr_we) begin
                curr_events++;
                seen_curr = curr_next;
                chk(curr_next == exp_curr, "R6 updated page", curr_next, exp_curr);
            end
        end
    end

    task automatic push(input int a, input int v, input string t);
        exp_addr.push_back(a);
        exp_data.push_back(v);
        exp_tag.push_back(t);
    endtask

    task automatic build_frame(input logic [47:0] dest, input int n);
        frame_q.delete();
        for (int i = 0; i < n; i++) begin
            if (i < 6) frame_q.push_back(dest[47-8*i -: 8]);
            else frame_q.push_back(8'((i * 13 + n) & 8'hFF));
        end
    endtask

    // Behavioural expectation for the frame in frame_q
    task automatic model_frame(output bit accepted);
        int n, len, pages, c;
        bit bc, uc;
        accepted = 0;
        if (model_lock) return;
        n = frame_q.size();
        bc = 1; uc = 1;
        for (int i = 0; i < 6 && i < n; i++) begin
            bc = bc && (frame_q[i] == 8'hFF);
            uc = uc && (frame_q[i] == STN[47-8*i -: 8]);
            if (!(bc || uc)) return;
            push(4 + i, frame_q[i], "R3 destination byte");
        end
        if (n < 6) return;
        for (int i = 6; i < n && i < 1536; i++) push(4 + i, frame_q[i], "R3 data byte");
        if (n > 1536) return;
        len = (n < 64) ? 64 : n;
        for (int i = n; i < 64; i++) push(4 + i, 0, "R5 pad byte");
        pages = 1 + ((len + 4) >> 8);
        c = curr_reg;
        for (int p = 0; p < pages; p++) begin
            c = (c + 1) & 8'hFF;
            if (c == ring_stop) c = ring_start;
        end
        push(0, 1, "R7 status byte");
        push(1, c, "R6 next page byte");
        push(2, len & 8'hFF, "R5 length low");
        push(3, len >> 8, "R5 length high");
        exp_curr = c;
        irq_armed = 1;
        model_lock = 1;
        accepted = 1;
    endtask

    task automatic send_frame();
        for (int i = 0; i < frame_q.size(); i++) begin
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = (i == frame_q.size() - 1);
            rx_data  = frame_q[i];
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic run_frame(input logic [47:0] dest, input int n, input string tag);
        bit acc;
        int irq0, cev0;
        build_frame(dest, n);
        irq0 = irq_seen;
        cev0 = curr_events;
        model_frame(acc);
        send_frame();
        repeat (80) @(negedge clk);
        chk(exp_addr.size() == 0, {tag, " all expected writes made"}, exp_addr.size(), 0);
        chk(irq_seen - irq0 == int'(acc), {tag, " interrupt count"}, irq_seen - irq0, acc);
        chk(curr_events - cev0 == int'(acc), {tag, " page update count"}, curr_events - cev0, acc);
        chk(rx_busy == model_lock, {tag, " lock state"}, rx_busy, model_lock);
        if (acc) curr_reg = seen_curr;
    endtask

    task automatic ack_pulse();
        rx_ack = 1'b1;
        @(negedge clk);
        rx_ack = 1'b0;
        @(negedge clk);
        model_lock = 0;
        chk(rx_busy == 1'b0, "R9 lock after acknowledge", rx_busy, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!buf_we && !rx_irq && !curr_we && !rx_busy, "R1 reset state",
            {buf_we, rx_irq, curr_we, rx_busy}, 0);

        // R2 R5: broadcast short frame, padded to 64, one page
        run_frame(BCAST, 60, "R2 broadcast");
        // R9: frame while locked is fully ignored
        run_frame(STN, 100, "R9 locked frame");
        ack_pulse();
        ack_pulse();                                  // R9 acknowledge while idle: no effect
        // R6: own address, 252 bytes, two pages
        run_frame(STN, 252, "R6 two pages");
        ack_pulse();
        // R2 R3: destination diverging at byte 3, byte 5 and byte 0
        run_frame(48'h021A_4C00_E037, 80, "R2 mismatch at byte 3");
        run_frame(48'hFFFF_FFFF_FFFE, 80, "R2 mismatch at byte 5");
        run_frame(48'hFF1A_4C99_E037, 80, "R2 mixed destination");
        // R10: too short to carry a destination
        run_frame(BCAST, 4, "R10 short frame");
        // R6: wrap inside a two-page advance
        curr_reg = 8'h7E;
        run_frame(STN, 300, "R6 wrap two pages");
        chk(curr_reg == 8'h46, "R6 wrapped page value", curr_reg, 8'h46);
        ack_pulse();
        // R5 R6: maximum length, seven pages across the wrap
        curr_reg = 8'h7D;
        run_frame(BCAST, 1536, "R5 maximum frame");
        chk(curr_reg == 8'h4A, "R6 seven page advance", curr_reg, 8'h4A);
        ack_pulse();
        // R4: one byte too long
        run_frame(BCAST, 1537, "R4 oversize frame");
        // R5: exactly minimum length, no padding
        run_frame(STN, 64, "R5 minimum frame");
        ack_pulse();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

endmodule